// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Split End-of-Interrupt

This block collects interrupts from three classes of source (software-triggered, per-core private and shared peripheral), ranks them by a programmable priority, and raises one request line toward a processor core. Every source runs its own lifecycle with four states: inactive, pending, active, and active-and-pending. A level source tracks its input line. An edge source latches a rising edge. A software-triggered source latches a register write.

The core drives a small register port. Reading the acknowledge register returns the winning ID and moves that source to active. An end-of-interrupt write lowers the running priority. A control bit chooses whether that same write also ends the active state, or whether a separate deactivate write does it. Running priority is kept on a short stack of acknowledged priorities. Nested handlers can therefore preempt each other, and each drop goes back to the level that was in force before. A priority mask filters out everything at or below a programmable level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Software sources have IDs 0..NUM_SGI-1. Private line k has ID 16+k, and shared line k (src_line index NUM_PPI+k) has ID 32+k. A write to address 5 with wdata[9:0] = ID makes that software source pending. The same write naming any non-software ID has no effect.
- R2: A read of address 0 (acknowledge) returns on reg_rdata, in the cycle after the read, the ID of the eligible source with the lowest priority value. A tie goes to the lower ID. That source becomes active and leaves the eligible set.
- R3: An acknowledge read with nothing eligible returns 1023 and changes neither source states nor the running priority.
- R4: A level source whose line is still high at acknowledge becomes active-and-pending. It is pending again once deactivated. If its line fell before deactivation, it is inactive.
- R5: A rising edge on an edge source while it is active makes it active-and-pending. After deactivation it can be acknowledged once more.
- R6: With the split bit clear, a write to address 1 (EOI) with wdata[9:0] = ID drops the running priority by one level and deactivates the named ID.
- R7: The split bit is bit 0 of address 4, readable and writable. With it set, EOI only drops the running priority, and a write to address 2 (deactivate) with wdata[9:0] = ID ends the active state. With it clear, writes to address 2 are ignored.
- R8: irq_out is high when the best enabled pending source has a priority value strictly below the running priority. The running priority reads at address 6, and its idle value is 2**PRIO_W (16).
- R9: Address 3 holds the priority mask (bits PRIO_W:0, reset 2**PRIO_W). A source is presented or acknowledged only if its priority value is strictly below the mask.
- R10: Each acknowledge pushes its priority and each EOI pops one level, restoring the level before it. With STK_D levels in use, nothing is presented and acknowledge returns 1023.
- R11: A write to address 7 configures the source named by wdata[9:0]. Priority sits at wdata[16 +: PRIO_W], enable at bit 24 and edge trigger at bit 25. Software sources are always edge. A disabled source keeps its pending state but is not presented until enabled.
- R12: After reset, irq_out is 0, all sources are disabled level sources, the running priority and mask read 16, and the split bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line | input | NUM_PPI+NUM_SPI | Private lines first, then shared lines |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after a read |
| irq_out | output | 1 | Registered interrupt request to the core |

## Verification
The bench targets the active-and-pending state in both the level and edge forms. A design that dropped it would lose the second interrupt after deactivation, and one that kept the pending bit on a falling level line would return a stale ID. It checks split mode in both directions: an EOI that deactivates in split mode lets an interrupt be acknowledged twice, and a deactivate write honoured in non-split mode frees a source whose handler is still running. It also fills the priority stack and drains it one level at a time. A flat running-priority register would go straight to idle after the first drop, and a missing full check would overrun storage. Equal priorities, masking at the exact boundary value, and disabled sources that keep their pending state are each compared against a behavioural model on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  localparam logic [3:0] A_ACK   = 4'd0;
  localparam logic [3:0] A_EOI   = 4'd1;
  localparam logic [3:0] A_DEACT = 4'd2;
  localparam logic [3:0] A_PMR   = 4'd3;
  localparam logic [3:0] A_CTRL  = 4'd4;
  localparam logic [3:0] A_SGI   = 4'd5;
  localparam logic [3:0] A_RPR   = 4'd6;
  localparam logic [3:0] A_CFG   = 4'd7;

  localparam int CFG_PRIO_LSB = 16;
  localparam int CFG_EN_BIT   = 24;
  localparam int CFG_EDGE_BIT = 25;

  // Source index to interrupt ID: software block, private block at 16, shared at 32
  function automatic logic [ID_W-1:0] id_of(input int idx, input int nsgi, input int nppi);
    if (idx < nsgi)             return ID_W'(idx);
    else if (idx < nsgi + nppi) return ID_W'(16 + idx - nsgi);
    else                        return ID_W'(32 + idx - nsgi - nppi);
  endfunction
endpackage

// File: rtl/irqc_source.sv
module irqc_source
  import irqc_pkg::*;
#(
  parameter int              PRIO_W = 4,
  parameter logic [ID_W-1:0] SRC_ID = '0,
  parameter bit              IS_SGI = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  input  logic [ID_W-1:0]   op_id,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic              cfg_edge,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              sgi_we,
  input  logic              deact_we,
  input  logic              ack_me,
  output logic              ready,
  output logic [PRIO_W-1:0] prio
);
  logic en_q, edge_q, line_q, pend_q, act_q;
  logic hit, rise, is_edge;

  assign hit     = (op_id == SRC_ID);
  assign is_edge = IS_SGI | edge_q;
  assign rise    = IS_SGI ? (sgi_we & hit) : (line & ~line_q);
  assign ready   = en_q & pend_q & ~act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      edge_q <= 1'b0;
      prio   <= '0;
      line_q <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      line_q <= line;
      if (cfg_we && hit) begin
        en_q   <= cfg_en;
        edge_q <= cfg_edge;
        prio   <= cfg_prio;
      end
      // pending half of the lifecycle
      if (!is_edge)    pend_q <= line;
      else if (rise)   pend_q <= 1'b1;
      else if (ack_me) pend_q <= 1'b0;
      // active half of the lifecycle
      if (ack_me)                act_q <= 1'b1;
      else if (deact_we && hit)  act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 3
) (
  input  logic [NSRC-1:0]             ready,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  output logic                        found,
  output logic [IDX_W-1:0]            idx,
  output logic [PRIO_W-1:0]           best
);
  // Scan in ID order; strict compare keeps the lower ID on ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (ready[i] && (!found || prio[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irqc_prio_stack.sv
module irqc_prio_stack #(
  parameter int PRIO_W = 4,
  parameter int STK_D  = 4,
  localparam int DW    = $clog2(STK_D + 1),
  localparam int IW    = (STK_D > 1) ? $clog2(STK_D) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_val,
  input  logic              pop,
  output logic [PRIO_W:0]   running,
  output logic [DW-1:0]     depth,
  output logic              full
);
  localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

  logic [PRIO_W-1:0] mem [STK_D];
  logic [IW-1:0]     top_idx;

  assign full    = (depth == DW'(STK_D));
  assign top_idx = IW'(depth - 1'b1);
  assign running = (depth == '0) ? IDLE : {1'b0, mem[top_idx]};

  always_ff @(posedge clk) begin
    if (push && !full) mem[IW'(depth)] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst)                          depth <= '0;
    else if (push && !full)           depth <= depth + 1'b1;
    else if (pop && depth != '0)      depth <= depth - 1'b1;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SGI = 2,
  parameter int NUM_PPI = 2,
  parameter int NUM_SPI = 4,
  parameter int PRIO_W  = 4,
  parameter int STK_D   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PPI+NUM_SPI-1:0] src_line,
  input  logic                       reg_en,
  input  logic                       reg_we,
  input  logic [3:0]                 reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       irq_out
);
  localparam int NSRC  = NUM_SGI + NUM_PPI + NUM_SPI;
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int DW    = $clog2(STK_D + 1);
  localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

  logic                        rd, wr, rd_ack, ack_hit, eoi_we, deact_now;
  logic                        cfg_we, sgi_we, split;
  logic [PRIO_W:0]             pmr, running;
  logic [ID_W-1:0]             op_id, win_id;
  logic [NSRC-1:0]             ready;
  logic [NSRC-1:0][PRIO_W-1:0] prio_v;
  logic                        found, elig, stk_full;
  logic [IDX_W-1:0]            win_idx;
  logic [PRIO_W-1:0]           win_prio;
  logic [DW-1:0]               stk_depth;
  logic                        wdata_unused;

  assign rd        = reg_en & ~reg_we;
  assign wr        = reg_en & reg_we;
  assign op_id     = reg_wdata[ID_W-1:0];
  assign rd_ack    = rd && (reg_addr == A_ACK);
  assign eoi_we    = wr && (reg_addr == A_EOI);
  assign cfg_we    = wr && (reg_addr == A_CFG);
  assign sgi_we    = wr && (reg_addr == A_SGI);
  assign deact_now = (eoi_we && !split) || (wr && (reg_addr == A_DEACT) && split);
  assign wdata_unused = ^{reg_wdata[31:26], reg_wdata[23:10]};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam logic [ID_W-1:0] SID = id_of(s, NUM_SGI, NUM_PPI);
    logic line_s;
    if (s < NUM_SGI) begin : g_sw
      assign line_s = 1'b0;
    end else begin : g_hw
      assign line_s = src_line[s-NUM_SGI];
    end
    irqc_source #(.PRIO_W(PRIO_W), .SRC_ID(SID), .IS_SGI(s < NUM_SGI)) u_src (
      .clk      (clk),
      .rst      (rst),
      .line     (line_s),
      .op_id    (op_id),
      .cfg_we   (cfg_we),
      .cfg_en   (reg_wdata[CFG_EN_BIT]),
      .cfg_edge (reg_wdata[CFG_EDGE_BIT]),
      .cfg_prio (reg_wdata[CFG_PRIO_LSB +: PRIO_W]),
      .sgi_we   (sgi_we),
      .deact_we (deact_now),
      .ack_me   (ack_hit && (win_idx == IDX_W'(s))),
      .ready    (ready[s]),
      .prio     (prio_v[s])
    );
  end

  irqc_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
    .ready (ready),
    .prio  (prio_v),
    .found (found),
    .idx   (win_idx),
    .best  (win_prio)
  );

  irqc_prio_stack #(.PRIO_W(PRIO_W), .STK_D(STK_D)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .push     (ack_hit),
    .push_val (win_prio),
    .pop      (eoi_we),
    .running  (running),
    .depth    (stk_depth),
    .full     (stk_full)
  );

  assign win_id  = id_of(int'(win_idx), NUM_SGI, NUM_PPI);
  assign elig    = found && ({1'b0, win_prio} < running) && ({1'b0, win_prio} < pmr) && !stk_full;
  assign ack_hit = rd_ack && elig;

  always_ff @(posedge clk) begin
    if (rst) begin
      pmr     <= IDLE;
      split   <= 1'b0;
      irq_out <= 1'b0;
    end else begin
      irq_out <= elig;
      if (wr && reg_addr == A_PMR)  pmr   <= reg_wdata[PRIO_W:0];
      if (wr && reg_addr == A_CTRL) split <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (rd) begin
      case (reg_addr)
        A_ACK:   reg_rdata <= elig ? 32'(win_id) : 32'(SPURIOUS_ID);
        A_PMR:   reg_rdata <= 32'(pmr);
        A_CTRL:  reg_rdata <= {31'b0, split};
        A_RPR:   reg_rdata <= 32'(running);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int PRIO_W = 4,
  parameter int STK_D  = 4,
  localparam int DW    = $clog2(STK_D + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_ack,
  input logic            ack_hit,
  input logic            elig,
  input logic            eoi_we,
  input logic            stk_full,
  input logic [DW-1:0]   stk_depth,
  input logic [PRIO_W:0] running,
  input logic            irq_out,
  input logic [31:0]     reg_rdata
);
  localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

  a_r3_spurious_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !elig) |=> (reg_rdata == 32'd1023) && $stable(stk_depth));

  a_r2_ack_pushes_level: assert property (@(posedge clk) disable iff (rst)
    ack_hit |=> stk_depth == DW'($past(stk_depth) + 1'b1));

  a_r8_nested_is_higher: assert property (@(posedge clk) disable iff (rst)
    ack_hit |=> running < $past(running));

  a_r10_drop_one_level: assert property (@(posedge clk) disable iff (rst)
    (eoi_we && stk_depth != '0) |=> stk_depth == DW'($past(stk_depth) - 1'b1));

  a_r10_full_blocks_irq: assert property (@(posedge clk) disable iff (rst)
    stk_full |=> !irq_out);

  a_r10_depth_bounded: assert property (@(posedge clk) disable iff (rst)
    stk_depth <= DW'(STK_D));

  a_r12_idle_when_empty: assert property (@(posedge clk) disable iff (rst)
    (stk_depth == '0) |-> running == IDLE);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.PRIO_W(PRIO_W), .STK_D(STK_D)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_ack    (rd_ack),
  .ack_hit   (ack_hit),
  .elig      (elig),
  .eoi_we    (eoi_we),
  .stk_full  (stk_full),
  .stk_depth (stk_depth),
  .running   (running),
  .irq_out   (irq_out),
  .reg_rdata (reg_rdata)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  localparam int NSRC = 8;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  src_line = '0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .src_line(src_line), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic int mid(int s);
    if (s < 2) return s;
    else if (s < 4) return 16 + s - 2;
    else return 32 + s - 4;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_pend[NSRC], m_act[NSRC], m_en[NSRC], m_edge[NSRC], m_lq[NSRC];
  int m_prio[NSRC];
  int m_stk[$];
  int m_pmr, m_rdata;
  bit m_split, m_irq;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_pend[s]) begin
        m_pend[s] = 0; m_act[s] = 0; m_en[s] = 0; m_edge[s] = 0; m_lq[s] = 0; m_prio[s] = 0;
      end
      m_stk.delete();
      m_pmr = 16; m_split = 0; m_irq = 0; m_rdata = 0;
    end else begin
      int c, cp, run, id;
      bit el, rd, wr, ack, dea, lv, edg, rise;
      c = -1; cp = 99;
      for (int s = 0; s < NSRC; s++)
        if (m_en[s] && m_pend[s] && !m_act[s] && m_prio[s] < cp) begin c = s; cp = m_prio[s]; end
      run = (m_stk.size() == 0) ? 16 : m_stk[$];
      el  = (c >= 0) && cp < run && cp < m_pmr && m_stk.size() < DEPTH;
      rd  = reg_en && !reg_we;
      wr  = reg_en && reg_we;
      id  = int'(reg_wdata[9:0]);
      ack = rd && reg_addr == 0 && el;
      dea = wr && ((reg_addr == 1 && !m_split) || (reg_addr == 2 && m_split));
      for (int s = 0; s < NSRC; s++) begin
        lv   = (s < 2) ? 1'b0 : src_line[(s < 2) ? 0 : s - 2];
        edg  = (s < 2) || m_edge[s];
        rise = (s < 2) ? (wr && reg_addr == 5 && id == mid(s)) : (lv && !m_lq[s]);
        if (!edg) m_pend[s] = lv;
        else if (rise) m_pend[s] = 1;
        else if (ack && s == c) m_pend[s] = 0;
        if (ack && s == c) m_act[s] = 1;
        else if (dea && id == mid(s)) m_act[s] = 0;
        m_lq[s] = lv;
        if (wr && reg_addr == 7 && id == mid(s)) begin
          m_en[s] = reg_wdata[24]; m_edge[s] = reg_wdata[25]; m_prio[s] = int'(reg_wdata[19:16]);
        end
      end
      if (ack) m_stk.push_back(cp);
      if (wr && reg_addr == 1 && m_stk.size() > 0) void'(m_stk.pop_back());
      if (wr && reg_addr == 3) m_pmr = int'(reg_wdata[4:0]);
      if (wr && reg_addr == 4) m_split = reg_wdata[0];
      if (rd) begin
        case (reg_addr)
          4'd0: m_rdata = el ? mid(c) : 1023;
          4'd3: m_rdata = m_pmr;
          4'd4: m_rdata = m_split;
          4'd6: m_rdata = run;
          default: m_rdata = 0;
        endcase
      end
      m_irq = el;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(irq_out === m_irq, "R8 irq_out vs model", int'(irq_out), int'(m_irq));
      check(reg_rdata === m_rdata, "R2 reg_rdata vs model", int'(reg_rdata), m_rdata);
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic wr(input int a, input int d);
    reg_en = 1; reg_we = 1; reg_addr = 4'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    reg_en = 1; reg_we = 0; reg_addr = 4'(a);
    @(negedge clk);
    reg_en = 0;
    d = int'(reg_rdata);
  endtask

  task automatic cfg(input int id, input int p, input int en, input int edg);
    wr(7, (edg << 25) | (en << 24) | (p << 16) | id);
  endtask

  task automatic expect_rd(input int a, input int exp, input string tag);
    int d;
    rd(a, d);
    check(d == exp, tag, d, exp);
  endtask

  task automatic pulse(input int li);
    src_line[li] = 1'b1;
    @(negedge clk);
    src_line[li] = 1'b0;
  endtask

  task automatic expect_irq(input bit exp, input string tag);
    @(negedge clk);
    @(negedge clk);
    check(irq_out == exp, tag, int'(irq_out), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check(irq_out == 1'b0, "R12 irq_out after reset", int'(irq_out), 0);
    expect_rd(6, 16, "R12 running priority idle");
    expect_rd(3, 16, "R12 mask reset value");
    expect_rd(4, 0, "R12 split bit reset");
    expect_rd(0, 1023, "R3 spurious after reset");

    // R2 tie on priority, R8 preemption
    cfg(32, 5, 1, 0); cfg(16, 5, 1, 0); cfg(33, 3, 1, 1);
    src_line[2] = 1; src_line[0] = 1;
    expect_irq(1, "R8 irq raised for pending level");
    expect_rd(0, 16, "R2 tie goes to lower ID");
    expect_rd(6, 5, "R8 running after ack");
    expect_irq(0, "R8 equal priority does not preempt");
    pulse(3);
    expect_irq(1, "R8 higher priority presented");
    expect_rd(0, 33, "R1 shared line 1 maps to ID 33");
    expect_rd(6, 3, "R8 running after nested ack");
    wr(1, 33);
    expect_rd(6, 5, "R10 drop restores previous level");
    wr(1, 16);
    expect_rd(6, 16, "R6 drop to idle");
    expect_rd(0, 16, "R4 level still high returns to pending");
    src_line[0] = 0;
    wr(1, 16);
    expect_rd(0, 32, "R4 level dropped leaves inactive");
    src_line[2] = 0;
    wr(1, 32);
    expect_rd(0, 1023, "R3 nothing eligible");
    expect_rd(6, 16, "R3 running unchanged by spurious");

    // R5 edge retrigger while active
    pulse(3);
    expect_rd(0, 33, "R5 first edge acked");
    pulse(3);
    wr(1, 33);
    expect_rd(0, 33, "R5 retrigger acked after deactivate");
    wr(1, 33);
    expect_rd(0, 1023, "R5 no extra interrupt");

    // R7 split mode
    wr(4, 1);
    expect_rd(4, 1, "R7 split bit reads back");
    pulse(3);
    expect_rd(0, 33, "R7 ack in split mode");
    wr(1, 33);
    expect_rd(6, 16, "R7 EOI drops running priority");
    pulse(3);
    @(negedge clk);
    expect_rd(0, 1023, "R7 EOI alone keeps source active");
    wr(2, 33);
    expect_rd(0, 33, "R7 deactivate releases pending copy");
    wr(1, 33); wr(2, 33);
    expect_rd(0, 1023, "R7 fully retired");
    // deactivate write ignored in non-split mode
    wr(4, 0);
    pulse(3);
    expect_rd(0, 33, "R7 ack in non-split mode");
    wr(2, 33);
    pulse(3);
    wr(1, 16);
    expect_rd(0, 1023, "R7 deactivate ignored without split");
    wr(1, 33);
    expect_rd(0, 33, "R6 EOI deactivates named ID");
    wr(1, 33);

    // R9 priority mask
    wr(3, 3);
    expect_rd(3, 3, "R9 mask reads back");
    pulse(3);
    expect_irq(0, "R9 priority equal to mask blocked");
    expect_rd(0, 1023, "R9 masked ack spurious");
    wr(3, 4);
    expect_irq(1, "R9 priority below mask presented");
    expect_rd(0, 33, "R9 ack after mask raised");
    wr(1, 33);
    wr(3, 16);

    // R11 enable gating
    cfg(17, 2, 0, 1);
    pulse(1);
    @(negedge clk);
    expect_rd(0, 1023, "R11 disabled source not presented");
    cfg(17, 2, 1, 1);
    expect_rd(0, 17, "R11 pending kept while disabled");
    wr(1, 17);

    // R1 software sources
    cfg(1, 7, 1, 0);
    wr(5, 1);
    expect_rd(0, 1, "R1 software write raises ID 1");
    wr(1, 1);
    wr(5, 16);
    expect_rd(0, 1023, "R1 software write to private ID ignored");

    // R10 stack depth
    cfg(0, 8, 1, 0); cfg(1, 6, 1, 0); cfg(34, 4, 1, 1); cfg(35, 2, 1, 1); cfg(17, 1, 1, 1);
    wr(5, 0);
    expect_rd(0, 0, "R10 level 1");
    wr(5, 1);
    expect_rd(0, 1, "R10 level 2");
    pulse(4);
    expect_rd(0, 34, "R10 level 3");
    pulse(5);
    expect_rd(0, 35, "R10 level 4");
    expect_rd(6, 2, "R10 running at full depth");
    pulse(1);
    expect_irq(0, "R10 full stack blocks request");
    expect_rd(0, 1023, "R10 full stack ack spurious");
    wr(1, 35);
    expect_rd(6, 4, "R10 drop from full");
    expect_rd(0, 17, "R10 waiting source taken after drop");
    expect_rd(6, 1, "R10 running after re-push");
    wr(1, 17);
    expect_rd(6, 4, "R10 unwind level 3");
    wr(1, 34);
    expect_rd(6, 6, "R10 unwind level 2");
    wr(1, 1);
    expect_rd(6, 8, "R10 unwind level 1");
    wr(1, 0);
    expect_rd(6, 16, "R10 unwind to idle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule